// File: doc/BRIEF.md
# Fixed-Priority Non-Preemptive Bus Arbiter

This block shares one system bus among up to seven processing units. Each unit has its own request line and its own grant line. A unit asks for the bus by driving its active-low select line low. The arbiter is built from registers clocked by one system clock. When the bus is idle, it grants the bus to the requesting unit with the lowest index. The owner then keeps the bus for as long as it holds its request, so a burst of accesses cannot be broken up by a higher-priority unit.

Each unit also has a ready line. Ready is low while the unit requests and has no grant, which makes that unit insert wait states. Ready is high when the unit is not requesting or when it owns the bus. The reset input is asynchronous. It passes through a short flip-flop synchronizer, so it clears the arbiter at once and releases it on a clock edge. This block does not route bus data.

Top module: `mbus_arbiter`

## Requirements
- R1: While reset is active (the asynchronous reset is low, or the synchronizer has not yet released it), every grant output is 0. Asserting the asynchronous reset clears the grants without waiting for a clock edge.
- R2: After the asynchronous reset is released, grants stay 0 through the first SYNC_STAGES rising clock edges (default 2). The earliest grant appears after edge SYNC_STAGES+1.
- R3: Master i requests when sel_n[i] is 0. When no grant is active, a request sampled at a rising edge produces a grant (gnt[i]=1) after that same edge. A grant is only given to a master that was requesting.
- R4: When the bus is idle and several masters request at once, the master with the lowest index gets the grant.
- R5: A master that holds the grant keeps it on every edge at which its request is still present, even when lower-index masters request.
- R6: When the owner's request is absent at a rising edge, all grants drop to 0 at that edge. A new grant can be issued at the next edge.
- R7: At most one grant bit is 1 at any time.
- R8: rdy[i] is 1 when master i does not request (sel_n[i]=1) or holds the grant. It is 0 when master i requests without a grant. rdy follows sel_n with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, synchronized inside the block |
| sel_n | input | N_MASTERS | Active-low bus request, one bit per master |
| gnt | output | N_MASTERS | Active-high bus grant, one bit per master |
| rdy | output | N_MASTERS | Per-master ready, low means insert a wait state |

## Verification
Directed steps come first.
- All masters request together as reset releases. This separates the synchronizer latency from the selection of the lowest index.
- The owner drops its request while others keep theirs. This shows the idle cycle on release and hands the bus to the next index.
- The index-0 master then requests again while index 1 owns the bus. This tells non-preemptive holding apart from a plain priority encoder.

A long random phase follows. Each request line flips with low probability, giving bursts of mixed length and frequent overlaps between masters. Every cycle is compared against a bench model of grant and ready, so ownership hand-offs under many different orderings are covered.

// File: rtl/mbus_arb_pkg.sv
package mbus_arb_pkg;
   localparam int unsigned ARB_MAX_MASTERS = 7;
   localparam int unsigned ARB_MIN_SYNC    = 1;
endpackage

// File: rtl/mbus_rst_sync.sv
module mbus_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n
);
   generate
      if (STAGES < mbus_arb_pkg::ARB_MIN_SYNC) begin : g_bad
         $error("mbus_rst_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         logic q;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) q <= 1'b0;
            else         q <= 1'b1;
         end
         assign rst_n = q;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) sh <= '0;
            else         sh <= {sh[STAGES-2:0], 1'b1};
         end
         assign rst_n = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mbus_prio_pick.sv
module mbus_prio_pick #(
   parameter int unsigned N         = 7,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] win_o
);
   generate
      if (LOW_FIRST) begin : g_low
         assign win_o = req_i & (~req_i + {{(N-1){1'b0}}, 1'b1});
      end else begin : g_high
         always_comb begin
            win_o = '0;
            for (int i = 0; i < N; i++) begin
               if (req_i[i]) win_o = ({{(N-1){1'b0}}, 1'b1} << i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mbus_owner_reg.sv
module mbus_owner_reg #(
   parameter int unsigned N         = 7,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   logic [N-1:0] win;
   logic [N-1:0] gnt_q;
   logic [N-1:0] gnt_d;
   logic         busy;
   logic         held;

   mbus_prio_pick #(.N(N), .LOW_FIRST(LOW_FIRST)) u_pick (
      .req_i (req),
      .win_o (win)
   );

   assign busy = (gnt_q != '0);
   assign held = ((gnt_q & req) != '0);

   always_comb begin
      if (busy) gnt_d = held ? gnt_q : '0;
      else      gnt_d = win;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gnt_q <= '0;
      else        gnt_q <= gnt_d;
   end

   assign gnt = gnt_q;

   p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_q));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt_q & req) != '0) |=> (gnt_q == $past(gnt_q)));

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt_q != '0) && ((gnt_q & req) == '0)) |=> (gnt_q == '0));

   p_grant_requested_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_q == '0) |=> ((gnt_q == '0) || ((gnt_q & $past(req)) != '0)));

   generate
      if (LOW_FIRST) begin : g_chk_low
         p_pick_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_q == '0) |=> ((gnt_q == '0) || (((gnt_q - 1'b1) & $past(req)) == '0)));
      end
   endgenerate
endmodule

// File: rtl/mbus_arbiter.sv
module mbus_arbiter #(
   parameter int unsigned N_MASTERS   = 7,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          LOW_FIRST   = 1'b1
) (
   input  logic                 clk,
   input  logic                 arst_n,
   input  logic [N_MASTERS-1:0] sel_n,
   output logic [N_MASTERS-1:0] gnt,
   output logic [N_MASTERS-1:0] rdy
);
   logic                 rst_n;
   logic [N_MASTERS-1:0] req;

   generate
      if (N_MASTERS < 1 || N_MASTERS > mbus_arb_pkg::ARB_MAX_MASTERS) begin : g_bad_n
         $error("mbus_arbiter: N_MASTERS out of range");
      end
   endgenerate

   mbus_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk    (clk),
      .arst_n (arst_n),
      .rst_n  (rst_n)
   );

   assign req = ~sel_n;

   mbus_owner_reg #(.N(N_MASTERS), .LOW_FIRST(LOW_FIRST)) u_own (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .gnt   (gnt)
   );

   generate
      for (genvar m = 0; m < N_MASTERS; m++) begin : g_rdy
         assign rdy[m] = sel_n[m] | gnt[m];
         p_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_n[m] && !gnt[m]) |-> !rdy[m]);
      end
   endgenerate

   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |-> (gnt == '0));
endmodule

// File: tb/mbus_arbiter_tb.sv
module mbus_arbiter_tb_top;
   localparam int N = 7;
   localparam int SYNC = 2;

   logic         clk = 1'b0;
   logic         arst_n = 1'b0;
   logic [N-1:0] sel_n = '1;
   logic [N-1:0] gnt;
   logic [N-1:0] rdy;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [N-1:0] exp_gnt = '0;
   int           rcnt = 0;

   always #10 clk = ~clk;

   mbus_arbiter #(.N_MASTERS(N), .SYNC_STAGES(SYNC), .LOW_FIRST(1'b1)) dut_i (
      .clk(clk), .arst_n(arst_n), .sel_n(sel_n), .gnt(gnt), .rdy(rdy)
   );

   function automatic logic [N-1:0] lowest(input logic [N-1:0] r);
      for (int i = 0; i < N; i++) if (r[i]) return ({{(N-1){1'b0}}, 1'b1} << i);
      return '0;
   endfunction

   function automatic logic [N-1:0] next_gnt(input logic [N-1:0] g, input logic [N-1:0] r);
      if (g != '0) return ((g & r) != '0) ? g : '0;
      return lowest(r);
   endfunction

   always @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         rcnt <= 0;
         exp_gnt <= '0;
      end else begin
         if (rcnt < SYNC) exp_gnt <= '0;
         else             exp_gnt <= next_gnt(exp_gnt, ~sel_n);
         if (rcnt < SYNC) rcnt <= rcnt + 1;
      end
   end

   task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic chk_model(input string tag);
      chk(gnt, exp_gnt, {tag, " grant vs model (R3 R4 R5 R6)"});
      chk(rdy, sel_n | exp_gnt, "R8 ready");
      checks++;
      if (!$onehot0(gnt)) begin
         failures++;
         $display("FAIL R7 actual=%b expected=at most one bit", gnt);
      end
   endtask

   task automatic cyc(input logic [N-1:0] s);
      sel_n = s;
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd4321));
      repeat (3) @(negedge clk);
      chk(gnt, '0, "R1 grants in reset");
      chk(rdy, '1, "R8 idle ready");
      sel_n = '0;
      #1;
      chk(rdy, '0, "R8 waiting ready");
      @(negedge clk);
      chk(gnt, '0, "R1 requests during reset");
      arst_n = 1'b1;
      cyc('0);
      chk(gnt, '0, "R2 edge1");
      cyc('0);
      chk(gnt, '0, "R2 edge2");
      cyc('0);
      chk(gnt, 7'b0000001, "R4 lowest wins");
      chk(rdy, 7'b0000001, "R8 owner ready");
      cyc(7'b0000001);
      chk(gnt, '0, "R6 release gap");
      chk(rdy, 7'b0000001, "R8 released ready");
      cyc(7'b0000001);
      chk(gnt, 7'b0000010, "R6 R4 next owner");
      cyc('0);
      chk(gnt, 7'b0000010, "R5 no preempt");
      cyc('0);
      chk(gnt, 7'b0000010, "R5 still held");
      chk_model("directed");
      arst_n = 1'b0;
      #1;
      chk(gnt, '0, "R1 async clear");
      @(negedge clk);
      arst_n = 1'b1;
      sel_n = '1;
      for (int c = 0; c < 4000; c++) begin
         logic [N-1:0] s;
         s = sel_n;
         for (int i = 0; i < N; i++) if ($urandom % 8 == 0) s[i] = ~s[i];
         cyc(s);
         chk_model("random");
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule